// File: doc/BRIEF.md
# Receive-Side In-Band Link Status Inserter

This block sits in a PHY's receive path, just ahead of the reduced-pin MAC interface. While a frame is being delivered, with receive data-valid high, it forwards the datapath nibble unchanged. Between frames, with data-valid low, it can put a status code on the same four data lines. The code tells the MAC whether the link is up, which receive clock rate is in use, and whether the link runs full or half duplex. The MAC can then follow link changes without polling the management registers.

The feature has its own enable input, which is treated as a configuration bit and held cleared by reset. When the feature is disabled, the idle nibble is all zeros. Every input, including the status inputs, passes through a capture stage and then an output stage. As a result, every input reaches the outputs exactly two clock edges later. A status change can only take effect at a clock edge, so it never splits one output nibble.

Top module: `ibs_inserter`

## Requirements
- R1: A synchronous active-high reset clears both output stages: `rx_dv_o` is 0 and `rxd_o` is 4'h0 after a reset edge. On the first edge after reset is released, the outputs still show this cleared state, even if the enable input is already high.
- R2: When `rx_dv_i` is 1, `rxd_o` equals `rxd_i` regardless of the enable and status inputs.
- R3: When `rx_dv_i` is 0 and `inband_en_i` is 1, `rxd_o` carries the status nibble {duplex, speed[1:0], link}.
- R4: Status bit 0 reports the link: 1 means link up, 0 means link down.
- R5: Status bits 2:1 carry the speed code: 2'b00 is 2.5 MHz, 2'b01 is 25 MHz and 2'b10 is 125 MHz.
- R6: Status bit 3 reports duplex: 1 means full duplex, 0 means half duplex.
- R7: When `rx_dv_i` is 0 and `inband_en_i` is 0, `rxd_o` is 4'h0.
- R8: The reserved speed code 2'b11 is placed on bits 2:1 unchanged.
- R9: Every input reaches the outputs exactly two rising clock edges later: `rx_dv_o` is `rx_dv_i` delayed by two cycles, and `rxd_o` follows the inputs seen two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_dv_i | input | 1 | Data-valid from the receive datapath |
| rxd_i | input | 4 | Data nibble from the receive datapath |
| link_up_i | input | 1 | Link state, 1 = up |
| full_dplx_i | input | 1 | Duplex, 1 = full |
| speed_i | input | 2 | Receive clock speed code |
| inband_en_i | input | 1 | Configuration bit that enables status insertion |
| rx_dv_o | output | 1 | Data-valid toward the MAC |
| rxd_o | output | 4 | Nibble driven toward the MAC |

## Verification
On every cycle, the assertions check the following:
- the two-cycle delay of data-valid;
- frame pass-through;
- the zero nibble when the feature is disabled;
- the position of each status field against the inputs seen two edges earlier, including the reserved speed code;
- the cleared outputs after a reset edge.

Only the bench scenarios show the following:
- that the status nibble matches specific intended values under varied input patterns;
- that an early enable is masked on the first edge after reset;
- the exact cycle at which a data-valid transition appears at the outputs.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

    localparam int NIB_W = 4;
    localparam int SPD_W = 2;

    typedef enum logic [SPD_W-1:0] {
        SPD_2M5  = 2'b00,
        SPD_25M  = 2'b01,
        SPD_125M = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    // Field order matches the idle nibble from bit 3 down to bit 0.
    typedef struct packed {
        logic   full_dplx;
        speed_e speed;
        logic   link_up;
    } link_stat_t;

    typedef struct packed {
        logic             dv;
        logic [NIB_W-1:0] nib;
    } rx_beat_t;

    localparam rx_beat_t   BEAT_IDLE = '{dv: 1'b0, nib: '0};
    localparam link_stat_t STAT_DOWN = '{full_dplx: 1'b0, speed: SPD_2M5, link_up: 1'b0};

    function automatic logic [NIB_W-1:0] stat_nibble(input link_stat_t s);
        return {s.full_dplx, s.speed, s.link_up};
    endfunction

endpackage

// File: rtl/ibs_capture.sv
module ibs_capture
    import ibs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_beat_t   beat_d,
    input  link_stat_t stat_d,
    input  logic       en_d,
    output rx_beat_t   beat_q,
    output link_stat_t stat_q,
    output logic       en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= BEAT_IDLE;
            stat_q <= STAT_DOWN;
            en_q   <= 1'b0;
        end else begin
            beat_q <= beat_d;
            stat_q <= stat_d;
            en_q   <= en_d;
        end
    end

endmodule

// File: rtl/ibs_select.sv
module ibs_select
    import ibs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_beat_t   beat,
    input  link_stat_t stat,
    input  logic       en,
    output rx_beat_t   out_q
);

    rx_beat_t nxt;

    always_comb begin
        nxt.dv = beat.dv;
        if (beat.dv)
            nxt.nib = beat.nib;
        else if (en)
            nxt.nib = stat_nibble(stat);
        else
            nxt.nib = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= BEAT_IDLE;
        else     out_q <= nxt;
    end

endmodule

// File: rtl/ibs_inserter.sv
module ibs_inserter
    import ibs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_dv_i,
    input  logic [ibs_pkg::NIB_W-1:0] rxd_i,
    input  logic                   link_up_i,
    input  logic                   full_dplx_i,
    input  logic [ibs_pkg::SPD_W-1:0] speed_i,
    input  logic                   inband_en_i,
    output logic                   rx_dv_o,
    output logic [ibs_pkg::NIB_W-1:0] rxd_o
);

    rx_beat_t   beat_in, beat_s1, beat_out;
    link_stat_t stat_in, stat_s1;
    logic       en_s1;

    always_comb begin
        beat_in.dv        = rx_dv_i;
        beat_in.nib       = rxd_i;
        stat_in.full_dplx = full_dplx_i;
        stat_in.speed     = speed_e'(speed_i);
        stat_in.link_up   = link_up_i;
    end

    ibs_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .beat_d (beat_in),
        .stat_d (stat_in),
        .en_d   (inband_en_i),
        .beat_q (beat_s1),
        .stat_q (stat_s1),
        .en_q   (en_s1)
    );

    ibs_select u_sel (
        .clk   (clk),
        .rst   (rst),
        .beat  (beat_s1),
        .stat  (stat_s1),
        .en    (en_s1),
        .out_q (beat_out)
    );

    assign rx_dv_o = beat_out.dv;
    assign rxd_o   = beat_out.nib;

endmodule

// File: rtl/ibs_inserter_chk.sv
module ibs_inserter_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_dv_i,
    input logic [3:0] rxd_i,
    input logic       link_up_i,
    input logic       full_dplx_i,
    input logic [1:0] speed_i,
    input logic       inband_en_i,
    input logic       rx_dv_o,
    input logic [3:0] rxd_o
);

    // Clean edges seen since reset, saturating at 2.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end
    logic warm;
    assign warm = (since_rst == 2'd2);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!rx_dv_o && rxd_o == 4'h0));

    p_dv_delay_r9: assert property (@(posedge clk) disable iff (rst)
        warm |-> (rx_dv_o == $past(rx_dv_i, 2)));

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (warm && rx_dv_o) |-> (rxd_o == $past(rxd_i, 2)));

    p_idle_off_r7: assert property (@(posedge clk) disable iff (rst)
        (warm && !rx_dv_o && !$past(inband_en_i, 2)) |-> (rxd_o == 4'h0));

    p_link_r4: assert property (@(posedge clk) disable iff (rst)
        (warm && !rx_dv_o && $past(inband_en_i, 2)) |-> (rxd_o[0] == $past(link_up_i, 2)));

    p_speed_r5: assert property (@(posedge clk) disable iff (rst)
        (warm && !rx_dv_o && $past(inband_en_i, 2)) |-> (rxd_o[2:1] == $past(speed_i, 2)));

    p_duplex_r6: assert property (@(posedge clk) disable iff (rst)
        (warm && !rx_dv_o && $past(inband_en_i, 2)) |-> (rxd_o[3] == $past(full_dplx_i, 2)));

    p_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
        (warm && !rx_dv_o && $past(inband_en_i, 2) && $past(speed_i, 2) == 2'b11)
        |-> (rxd_o[2:1] == 2'b11));

endmodule

bind ibs_inserter ibs_inserter_chk u_chk (.*);

// File: tb/ibs_inserter_tb.sv
module ibs_inserter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_dv_i = 1'b0;
    logic [3:0] rxd_i = 4'h0;
    logic       link_up_i = 1'b0;
    logic       full_dplx_i = 1'b0;
    logic [1:0] speed_i = 2'b00;
    logic       inband_en_i = 1'b0;
    logic       rx_dv_o;
    logic [3:0] rxd_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ibs_inserter dut_i (.*);

    // Vector layout: {req[3:0], dv, data[3:0], link, dup, spd[1:0], en, exp[3:0]}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {4'd2, 1'b1, 4'hA, 1'b0, 1'b0, 2'b00, 1'b0, 4'hA}, // R2 pass, disabled
        {4'd2, 1'b1, 4'h5, 1'b1, 1'b1, 2'b10, 1'b1, 4'h5}, // R2 pass overrides status
        {4'd7, 1'b0, 4'hF, 1'b1, 1'b1, 2'b10, 1'b0, 4'h0}, // R7 idle, disabled
        {4'd3, 1'b0, 4'hF, 1'b1, 1'b1, 2'b10, 1'b1, 4'hD}, // R3 full status
        {4'd4, 1'b0, 4'h0, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0}, // R4 link down
        {4'd4, 1'b0, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 4'h1}, // R4 link up
        {4'd5, 1'b0, 4'h0, 1'b0, 1'b0, 2'b01, 1'b1, 4'h2}, // R5 25 MHz
        {4'd5, 1'b0, 4'h0, 1'b0, 1'b0, 2'b10, 1'b1, 4'h4}, // R5 125 MHz
        {4'd6, 1'b0, 4'h0, 1'b0, 1'b1, 2'b00, 1'b1, 4'h8}, // R6 full duplex
        {4'd8, 1'b0, 4'h9, 1'b0, 1'b0, 2'b11, 1'b1, 4'h6}, // R8 reserved code
        {4'd8, 1'b0, 4'h0, 1'b1, 1'b1, 2'b11, 1'b1, 4'hF}, // R8 reserved, all set
        {4'd2, 1'b1, 4'h0, 1'b1, 1'b1, 2'b11, 1'b1, 4'h0}  // R2 zero data in frame
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual {dv,rxd}=%b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", {rx_dv_o, rxd_o}, 5'b0_0000);

        // R1: enable already high when reset drops; first edge still cleared
        inband_en_i = 1'b1; link_up_i = 1'b1; full_dplx_i = 1'b1; speed_i = 2'b01;
        rst = 1'b0;
        @(posedge clk); #2;
        check("R1 first edge", {rx_dv_o, rxd_o}, 5'b0_0000);
        @(posedge clk); #2;
        check("R3 after reset", {rx_dv_o, rxd_o}, 5'b0_1011);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            rx_dv_i     = v[13];
            rxd_i       = v[12:9];
            link_up_i   = v[8];
            full_dplx_i = v[7];
            speed_i     = v[6:5];
            inband_en_i = v[4];
            @(posedge clk); @(posedge clk); #2;
            check($sformatf("R%0d vec %0d", v[17:14], i), {rx_dv_o, rxd_o}, {v[13], v[3:0]});
        end

        // R9: a frame start appears exactly two edges later
        rx_dv_i = 1'b0; inband_en_i = 1'b1; link_up_i = 1'b1; full_dplx_i = 1'b0; speed_i = 2'b10;
        @(posedge clk); @(posedge clk); #2;
        check("R9 settle", {rx_dv_o, rxd_o}, 5'b0_0101);
        rx_dv_i = 1'b1; rxd_i = 4'h9;
        @(posedge clk); #2;
        check("R9 one edge", {rx_dv_o, rxd_o}, 5'b0_0101);
        @(posedge clk); #2;
        check("R9 two edges", {rx_dv_o, rxd_o}, 5'b1_1001);
        rx_dv_i = 1'b0; link_up_i = 1'b0;
        @(posedge clk); #2;
        check("R9 end one edge", {rx_dv_o, rxd_o}, 5'b1_1001);
        @(posedge clk); #2;
        check("R9 end two edges", {rx_dv_o, rxd_o}, 5'b0_0100);

        // R7: disabling mid-gap drops to zeros two edges later
        inband_en_i = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        check("R7 disable in gap", {rx_dv_o, rxd_o}, 5'b0_0000);

        // R1: reset in mid-frame clears outputs
        rx_dv_i = 1'b1; rxd_i = 4'h7;
        @(posedge clk); @(posedge clk); #2;
        check("R2 frame before reset", {rx_dv_o, rxd_o}, 5'b1_0111);
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1 mid-frame reset", {rx_dv_o, rxd_o}, 5'b0_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule